// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for clause 22 MDIO management frames. A host reaches two 32-bit registers over a plain synchronous register bus: a command word and a data word. One write to the command word, with its launch bit set, starts a complete read or write frame toward a PHY. While the frame runs, the block generates MDC from the system clock and either drives the MDIO line or releases it.

The command word holds everything a frame needs: the launch/busy flag, the transfer direction, a 3-bit code that picks the MDC division ratio, the target PHY address and the register number. For a write, the host loads the data word first and then launches. For a read, the host launches, polls the busy flag until it clears, and then reads the captured value from the data word. A launch is a single control action rather than a data stream, so the register bus has no valid/ready back-pressure. The only flow control is the busy flag, and the host polls it before the next access.

Top module: `mgmt_mdio_master`

## Requirements
- R1: After reset, busy is 0, MDC is low, the MDIO output enable is low, and both registers read as zero.
- R2: The command word (reg_addr 0) is laid out as follows: bit 0 is busy/launch, bit 1 is direction (1 = write to PHY, 0 = read), bits 4:2 are the clock-range code, bits 10:6 are the register number and bits 15:11 are the PHY address. Bit 5 and bits 31:16 read as 0. An idle write stores all the fields, and they read back unchanged.
- R3: An idle write to the command word with bit 0 = 1 launches a frame, and busy reads 1 from the next cycle until the frame ends. An idle write with bit 0 = 0 launches nothing: busy stays 0 and MDC stays low.
- R4: One MDC period lasts 42, 62, 16, 26, 102 or 124 clock cycles for codes 0 to 5. Codes 6 and 7 use 124. Each period is low for its first half and high for its second half. A frame is 64 MDC periods, so busy stays high for exactly 64 × ratio cycles.
- R5: A write frame keeps MDIO driven for the whole frame. Sampled on each MDC rising edge, it carries 32 ones, then 01, then opcode 01, then the PHY address MSB first, the register number MSB first, turnaround 10, and the 16 data bits MSB first.
- R6: A read frame sends opcode 10 and drives only the first 46 bits. It releases MDIO for the last 18 (turnaround plus data), samples mdio_i on the MDC rising edge of the last 16 bits (MSB first), and holds the result in the data word (reg_addr 1, bits 15:0) once busy clears.
- R7: Within a frame, mdio_o changes only on the clock edge where MDC falls.
- R8: Writes to either register while busy is 1 are ignored. The running frame, the stored command fields and the data word are all left untouched.
- R9: Whenever busy is 0, MDC is low and the MDIO output enable is low.
- R10: A data-word write while idle reads back in bits 15:0, with bits 31:16 reading as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = command word, 1 = data word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| busy | output | 1 | Frame in progress (same as command bit 0) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO value from the pad |

## Verification
Take the clock edge that accepts a launch write as edge 0. Busy is high from edge 0 through edge 64·ratio, when it drops. MDC first rises at edge ratio/2, and every later MDC level change comes ratio/2 edges after the previous one. The read result and the cleared busy flag appear together at the edge where busy drops. The bench drives all inputs and samples all outputs on the falling clock edge. It counts samples from the one right after the launch edge, so it can compare the busy length and the first MDC rise against exact counts. It records MDIO at each observed MDC rise and checks the data word only once busy reads 0.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DATA_W = 16;
  localparam int FIELD_W = 5;
  localparam int CR_W = 3;
  localparam int HALF_W = 7;

  typedef struct packed {
    logic [FIELD_W-1:0] phy;
    logic [FIELD_W-1:0] regn;
    logic [CR_W-1:0]    cr;
    logic               wr;
  } mdio_cmd_t;

  // Half of the MDC period, in system clocks, for a clock-range code.
  function automatic logic [HALF_W-1:0] half_period(input logic [CR_W-1:0] code);
    case (code)
      3'd0:    half_period = 7'd21;
      3'd1:    half_period = 7'd31;
      3'd2:    half_period = 7'd8;
      3'd3:    half_period = 7'd13;
      3'd4:    half_period = 7'd51;
      default: half_period = 7'd62;
    endcase
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [HALF_W-1:0] half,
  output logic              mdc,
  output logic              rise_tick,
  output logic              fall_tick
);
  localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

  logic [HALF_W-1:0] cnt;
  logic              mdc_q;
  logic              last;

  assign last      = (cnt == half - ONE);
  assign rise_tick = en & last & ~mdc_q;
  assign fall_tick = en & last & mdc_q;
  assign mdc       = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (last) begin
      cnt   <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt   <= cnt + ONE;
    end
  end
endmodule

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else if (STAGES == 1) begin : g_one
      logic ff;
      always_ff @(posedge clk) begin
        if (!rst_n) ff <= 1'b1;
        else        ff <= d;
      end
      assign q = ff;
    end else begin : g_chain
      logic [STAGES-1:0] ff;
      always_ff @(posedge clk) begin
        if (!rst_n) ff <= '1;
        else        ff <= {ff[STAGES-2:0], d};
      end
      assign q = ff[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int FRAME_W = PRE_LEN + 32,
  parameter int IDX_W   = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_cmd_t         cmd_in,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mdio_in,
  input  logic              rise_tick,
  input  logic              fall_tick,
  output logic              run,
  output logic              done,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic [IDX_W-1:0]  bit_idx
);
  localparam logic [IDX_W-1:0] LAST     = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] TA_POS   = IDX_W'(PRE_LEN + 14);
  localparam logic [IDX_W-1:0] DATA_POS = IDX_W'(PRE_LEN + 16);

  logic [FRAME_W-1:0] sh;
  logic [IDX_W-1:0]   idx;
  logic               run_q;
  logic               wr_q;
  logic [DATA_W-1:0]  cap;

  assign run     = run_q;
  assign done    = run_q & fall_tick & (idx == LAST);
  assign mdio_o  = sh[FRAME_W-1];
  assign mdio_oe = run_q & (wr_q | (idx < TA_POS));
  assign rd_data = cap;
  assign bit_idx = idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      wr_q  <= 1'b0;
      idx   <= '0;
      sh    <= '0;
      cap   <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      wr_q  <= cmd_in.wr;
      idx   <= '0;
      cap   <= '0;
      sh    <= {{PRE_LEN{1'b1}}, 2'b01, (cmd_in.wr ? 2'b01 : 2'b10),
                cmd_in.phy, cmd_in.regn, 2'b10, wr_data};
    end else if (run_q) begin
      if (rise_tick && !wr_q && idx >= DATA_POS)
        cap <= {cap[DATA_W-2:0], mdio_in};
      if (fall_tick) begin
        if (idx == LAST) begin
          run_q <= 1'b0;
        end else begin
          idx <= idx + IDX_W'(1);
          sh  <= sh << 1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rd_data,
  output logic [31:0]       reg_rdata,
  output logic              start,
  output mdio_cmd_t         cmd_new,
  output mdio_cmd_t         cmd_q,
  output logic [DATA_W-1:0] data_q,
  output logic [31:0]       cmd_word
);
  logic cmd_wr_ok;
  logic data_wr_ok;

  assign cmd_wr_ok  = reg_we & ~reg_addr & ~busy;
  assign data_wr_ok = reg_we &  reg_addr & ~busy;
  assign start      = cmd_wr_ok & reg_wdata[0];

  assign cmd_new.phy  = reg_wdata[15:11];
  assign cmd_new.regn = reg_wdata[10:6];
  assign cmd_new.cr   = reg_wdata[4:2];
  assign cmd_new.wr   = reg_wdata[1];

  assign cmd_word  = {16'b0, cmd_q.phy, cmd_q.regn, 1'b0, cmd_q.cr, cmd_q.wr, busy};
  assign reg_rdata = reg_addr ? {{(32-DATA_W){1'b0}}, data_q} : cmd_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (cmd_wr_ok)
        cmd_q <= cmd_new;
      if (data_wr_ok)
        data_q <= reg_wdata[DATA_W-1:0];
      else if (done && !cmd_q.wr)
        data_q <= rd_data;
    end
  end
endmodule

// File: rtl/mgmt_mdio_master.sv
module mgmt_mdio_master
  import mdio_pkg::*;
#(
  parameter int PRE_LEN     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        busy,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_W     = PRE_LEN + 32;
  localparam int FRAME_IDX_W = $clog2(FRAME_W);
  localparam int TA_POS      = PRE_LEN + 14;

  mdio_cmd_t               cmd_new;
  mdio_cmd_t               cmd_q;
  logic [DATA_W-1:0]       data_q;
  logic [DATA_W-1:0]       rd_data;
  logic [31:0]             cmd_word;
  logic [FRAME_IDX_W-1:0]  frame_idx;
  logic                    start;
  logic                    done;
  logic                    run;
  logic                    rise_tick;
  logic                    fall_tick;
  logic                    mdio_in_s;

  assign busy = run;

  mdio_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (run),
    .done      (done),
    .rd_data   (rd_data),
    .reg_rdata (reg_rdata),
    .start     (start),
    .cmd_new   (cmd_new),
    .cmd_q     (cmd_q),
    .data_q    (data_q),
    .cmd_word  (cmd_word)
  );

  mdio_clkgen #(.HALF_W(HALF_W)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (run),
    .half      (half_period(cmd_q.cr)),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (mdio_i),
    .q     (mdio_in_s)
  );

  mdio_frame #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd_in    (cmd_new),
    .wr_data   (data_q),
    .mdio_in   (mdio_in_s),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .run       (run),
    .done      (done),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rd_data   (rd_data),
    .bit_idx   (frame_idx)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int IDX_W  = 6,
  parameter int TA_POS = 46
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic             reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             busy,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic [31:0]      cmd_word,
  input logic [IDX_W-1:0] frame_idx
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R9

  AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_we && !reg_addr && reg_wdata[0]) |=> busy); // R3

  AST_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_we && !reg_addr && !reg_wdata[0]) |=> !busy); // R3

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_word[15:1])); // R8

  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_word[1]) |-> mdio_oe); // R5

  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_word[1] && frame_idx >= IDX_W'(TA_POS)) |-> !mdio_oe); // R6

  AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc)); // R7
endmodule

bind mgmt_mdio_master mdio_master_chk #(
  .IDX_W  (FRAME_IDX_W),
  .TA_POS (TA_POS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .busy      (busy),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .cmd_word  (cmd_word),
  .frame_idx (frame_idx)
);

// File: tb/mgmt_mdio_master_bench.sv
`timescale 1ns/1ps
module mgmt_mdio_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        busy, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  mgmt_mdio_master u_mgmt_mdio_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  function automatic int exp_ratio(input logic [2:0] cr);
    case (cr)
      3'd0: return 42;
      3'd1: return 62;
      3'd2: return 16;
      3'd3: return 26;
      3'd4: return 102;
      default: return 124;
    endcase
  endfunction

  function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, d};
  endfunction

  function automatic logic [31:0] exp_cmd(input logic wr, input logic [4:0] phy,
                                          input logic [4:0] rg, input logic [2:0] cr,
                                          input logic b);
    return {16'b0, phy, rg, 1'b0, cr, wr, b};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic run_frame(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [2:0] cr, input logic [15:0] wval,
                           input logic [15:0] phyval, input bit poke);
    int idx = 0, rises = 0, falls = 0, first_rise = -1, ratio;
    logic prev = 1'b0;
    logic [63:0] got = '0, oeb = '0, ef;
    logic [31:0] v;
    ratio = exp_ratio(cr);
    ef = exp_frame(wr, phy, rg, wval);
    if (wr) wr_reg(1'b1, {16'h0, wval});
    wr_reg(1'b0, exp_cmd(wr, phy, rg, cr, 1'b1));
    while (busy && idx < 20000) begin
      if (mdc && !prev) begin
        if (rises < 64) begin got[63-rises] = mdio_o; oeb[63-rises] = mdio_oe; end
        if (first_rise < 0) first_rise = idx;
        rises++;
      end
      if (!mdc && prev) falls++;
      mdio_i = (falls >= 48 && falls <= 63) ? phyval[63-falls] : 1'b1;
      prev = mdc;
      reg_we = 1'b0;
      if (poke && idx == 100) begin
        reg_we = 1'b1; reg_addr = 1'b0;
        reg_wdata = exp_cmd(~wr, ~phy, ~rg, ~cr, 1'b1);
      end
      if (poke && idx == 300) begin
        reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = 32'h0000_5A5A;
      end
      @(negedge clk);
      idx++;
    end
    reg_we = 1'b0;
    mdio_i = 1'b1;
    check(idx == 64 * ratio, "R4 busy length", 64'(idx), 64'(64 * ratio));
    check(first_rise == ratio / 2, "R4 first MDC rise", 64'(first_rise), 64'(ratio / 2));
    check(rises == 64, "R4 MDC periods", 64'(rises), 64'd64);
    if (wr) begin
      check(got == ef, "R5 write frame bits", got, ef);
      check(oeb == '1, "R5 drive enable", oeb, '1);
      rd_reg(1'b1, v);
      check(v == {16'h0, wval}, "R10 data kept after write (R8 poke)", 64'(v), 64'(wval));
    end else begin
      check(got[63:18] == ef[63:18], "R6 read header bits", 64'(got[63:18]), 64'(ef[63:18]));
      check(oeb == {{46{1'b1}}, 18'b0}, "R6 release pattern", oeb, {{46{1'b1}}, 18'b0});
      rd_reg(1'b1, v);
      check(v == {16'h0, phyval}, "R6 read result", 64'(v), 64'(phyval));
    end
    rd_reg(1'b0, v);
    check(v == exp_cmd(wr, phy, rg, cr, 1'b0), "R2 R8 command readback", 64'(v),
          64'(exp_cmd(wr, phy, rg, cr, 1'b0)));
    check(!mdc && !mdio_oe, "R9 idle lines", {62'b0, mdc, mdio_oe}, 64'd0);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int s;
    bit quiet;
    s = $urandom(32'h1BAD_5EED);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !mdc && !mdio_oe, "R1 reset lines", {61'b0, busy, mdc, mdio_oe}, 64'd0);
    rd_reg(1'b0, v); check(v == 32'h0, "R1 command reset", 64'(v), 64'd0);
    rd_reg(1'b1, v); check(v == 32'h0, "R1 data reset", 64'(v), 64'd0);
    // R10 data register readback
    wr_reg(1'b1, 32'hFFFF_1234);
    rd_reg(1'b1, v); check(v == 32'h0000_1234, "R10 data readback", 64'(v), 64'h1234);
    // R3 command with launch bit clear: fields stored, nothing starts
    wr_reg(1'b0, 32'hFFFF_FFFE);
    rd_reg(1'b0, v);
    check(v == exp_cmd(1'b1, 5'h1F, 5'h1F, 3'h7, 1'b0), "R2 field readback", 64'(v),
          64'(exp_cmd(1'b1, 5'h1F, 5'h1F, 3'h7, 1'b0)));
    quiet = 1'b1;
    for (int i = 0; i < 200; i++) begin
      if (busy || mdc || mdio_oe) quiet = 1'b0;
      @(negedge clk);
    end
    check(quiet, "R3 no launch without bit 0", 64'(quiet), 64'd1);
    // directed frames
    run_frame(1'b1, 5'h1F, 5'h00, 3'd2, 16'hA5C3, 16'h0000, 1'b1);
    run_frame(1'b0, 5'h00, 5'h1F, 3'd2, 16'h0000, 16'h8001, 1'b1);
    run_frame(1'b0, 5'h0A, 5'h15, 3'd6, 16'h0000, 16'h7FFE, 1'b0);
    run_frame(1'b1, 5'h15, 5'h0A, 3'd7, 16'h0001, 16'h0000, 1'b0);
    // every defined code once, random fields
    for (int c = 0; c < 6; c++)
      run_frame(1'($urandom), 5'($urandom), 5'($urandom), 3'(c), 16'($urandom),
                16'($urandom), 1'b0);
    // random mix
    for (int k = 0; k < 8; k++)
      run_frame(1'($urandom), 5'($urandom), 5'($urandom), 3'($urandom), 16'($urandom),
                16'($urandom), 1'($urandom));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule